// File: doc/BRIEF.md
# Threshold Trigger Front End with Busy Veto

This block sits behind the digitizer of a single detector channel. Each clock cycle it receives one sample and compares it with a programmable threshold. A sample above the threshold is a trigger candidate. A candidate that arrives while the block can take a new event starts a capture. The capture first stores a 16-bit event sequence number. It then stores a fixed-length window of samples, taken from a delayed copy of the input stream so that the window lines up with the pulse that fired the trigger.

Captured words go into a derandomizing queue. A slower consumer drains the queue through a valid/ready handshake. The block raises busy while a capture is in progress, and also whenever the queue lacks room for one complete event. Candidates seen while busy are dropped.

Three counters record candidates offered, events accepted and busy cycles. Software outside the block can work out the live fraction and the efficiency from these counts.

Top module: `trig_frontend`

## Requirements
- R1: After reset, busy and out_valid are low and all three counters read zero.
- R2: A sample is a trigger candidate only when it is strictly greater than the loaded threshold. A sample equal to the threshold is not a candidate.
- R3: An event accepted in cycle t is delivered as WIN_LEN+1 words. The first word is the sequence number, zero-extended; it is 0 for the first event after reset and increases by 1 for each later event. Sample word i (i = 0..WIN_LEN-1) is the input sample from cycle t+1+i-D, where D = cfg_delay+1 (range 1 to 32). Samples from before reset read as zero.
- R4: busy is high in the WIN_LEN cycles that follow an accepted trigger.
- R5: A candidate that arrives while busy is high is discarded. This includes a candidate in the last capture cycle. It adds no words to the output and does not advance the accepted count.
- R6: busy is also high in any cycle in which the queue has fewer than WIN_LEN+1 free words. The queue never overflows.
- R7: Words leave in the order they were written, one word per cycle in which out_valid and out_ready are both high. While out_valid is high and out_ready is low, out_valid and out_data hold their values.
- R8: cnt_offered counts candidate cycles, cnt_accepted counts accepted triggers and cnt_busy counts cycles with busy high. A cnt_clr pulse sets all three to zero on the next cycle, and the counts of that cycle are discarded.
- R9: When cfg_load is high and no capture is in progress, cfg_threshold and cfg_delay are loaded and take effect in the next cycle. A load requested during a capture is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_clr | input | 1 | Synchronous clear of the three counters |
| cfg_load | input | 1 | Load threshold and delay (honoured only when idle) |
| cfg_threshold | input | DATA_W | Trigger threshold |
| cfg_delay | input | DLY_AW | Data delay minus one |
| smp_in | input | DATA_W | Digitized sample, one per cycle |
| busy | output | 1 | Trigger veto |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Consumer accepts word |
| out_data | output | DATA_W | Header or sample word |
| cnt_offered | output | CNT_W | Trigger candidates seen |
| cnt_accepted | output | CNT_W | Triggers accepted |
| cnt_busy | output | CNT_W | Cycles spent busy |

## Verification
The stimulus starts with directed sequences:
- samples equal to and one above the threshold, which tell a strict compare apart from an inclusive one;
- a run of over-threshold samples during a capture, including one on the last capture cycle;
- a trigger in the first idle cycle after a capture;
- a load attempted in mid-capture;
- the longest delay, using a ramp input so that an off-by-one in the window position shows up as a wrong value.

A burst of triggers while the consumer is stalled forces the veto to come from queue space instead of from an active capture. Random samples then straddle a threshold that changes from time to time, while ready follows random and long-stall patterns. Every cycle is compared against a bench model of the event stream and the counters.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_CAP  = 1'b1
  } cap_state_e;
endpackage

// File: rtl/trig_delay_line.sv
module trig_delay_line #(
  parameter int DATA_W  = 16,
  parameter int MAX_DLY = 32,
  parameter int DLY_AW  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] smp_in,
  input  logic [DLY_AW-1:0] tap_sel,
  output logic [DATA_W-1:0] smp_out
);
  // stage k holds the sample from k+1 cycles ago
  logic [DATA_W-1:0] stage_q [MAX_DLY];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= smp_in;
  end

  for (genvar k = 1; k < MAX_DLY; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[k] <= '0;
      else        stage_q[k] <= stage_q[k-1];
    end
  end

  assign smp_out = stage_q[tap_sel];
endmodule

// File: rtl/trig_fifo.sv
module trig_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [AW:0]       free_words
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          rd_en, full;

  assign full       = (cnt_q == (AW+1)'(DEPTH));
  assign rd_valid   = (cnt_q != '0);
  assign rd_en      = rd_valid & rd_ready;
  assign rd_data    = mem[rd_ptr_q];
  assign free_words = (AW+1)'(DEPTH) - cnt_q;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (wr_en) wr_ptr_d = wr_ptr_q + 1'b1;
    if (rd_en) rd_ptr_d = rd_ptr_q + 1'b1;
    case ({wr_en, rd_en})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr_q] <= wr_data;
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> rd_valid);
  assert_hold_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

// File: rtl/trig_capture.sv
module trig_capture
  import trig_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int WIN_LEN = 4,
  parameter int DLY_AW  = 5,
  parameter int SEQ_W   = 16,
  parameter int FREE_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] smp_in,
  input  logic [DATA_W-1:0] dly_smp,
  input  logic              cfg_load,
  input  logic [DATA_W-1:0] cfg_threshold,
  input  logic [DLY_AW-1:0] cfg_delay,
  input  logic [FREE_W-1:0] free_words,
  output logic [DLY_AW-1:0] tap_sel,
  output logic              busy,
  output logic              cand,
  output logic              accept,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data
);
  localparam int EVT_WORDS = WIN_LEN + 1;
  localparam int LEFT_W    = $clog2(WIN_LEN + 1);

  cap_state_e        state_q, state_d;
  logic [LEFT_W-1:0] left_q, left_d;
  logic [SEQ_W-1:0]  seq_q, seq_d;
  logic [DATA_W-1:0] thr_q;
  logic [DLY_AW-1:0] dly_q;
  logic              idle, space_low, cfg_en, capturing;

  assign idle      = (state_q == ST_IDLE);
  assign capturing = (state_q == ST_CAP);
  assign space_low = (free_words < FREE_W'(EVT_WORDS));
  assign busy      = capturing | space_low;
  assign cand      = (smp_in > thr_q);
  assign accept    = cand & ~busy;
  assign wr_en     = accept | capturing;
  assign wr_data   = accept ? DATA_W'(seq_q) : dly_smp;
  assign cfg_en    = cfg_load & idle;
  assign tap_sel   = dly_q;

  always_comb begin
    state_d = state_q;
    left_d  = left_q;
    seq_d   = seq_q;
    if (accept) begin
      state_d = ST_CAP;
      left_d  = LEFT_W'(WIN_LEN);
      seq_d   = seq_q + 1'b1;
    end else if (capturing) begin
      left_d = left_q - 1'b1;
      if (left_q == LEFT_W'(1)) state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      seq_q   <= '0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
      seq_q   <= seq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= '0;
      dly_q <= '0;
    end else if (cfg_en) begin
      thr_q <= cfg_threshold;
      dly_q <= cfg_delay;
    end
  end

  assert_busy_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    capturing |=> ($stable(thr_q) && $stable(dly_q)));
  assert_one_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !accept);
endmodule

// File: rtl/trig_counters.sv
module trig_counters #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc_offered,
  input  logic             inc_accepted,
  input  logic             inc_busy,
  output logic [CNT_W-1:0] cnt_offered,
  output logic [CNT_W-1:0] cnt_accepted,
  output logic [CNT_W-1:0] cnt_busy
);
  localparam int NUM = 3;

  logic [NUM-1:0]   inc;
  logic [CNT_W-1:0] cnt_q [NUM];
  logic [CNT_W-1:0] cnt_d [NUM];

  assign inc = {inc_busy, inc_accepted, inc_offered};

  for (genvar i = 0; i < NUM; i++) begin : g_cnt
    always_comb begin
      if (clr)         cnt_d[i] = '0;
      else if (inc[i]) cnt_d[i] = cnt_q[i] + 1'b1;
      else             cnt_d[i] = cnt_q[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q[i] <= '0;
      else        cnt_q[i] <= cnt_d[i];
    end
  end

  assign cnt_offered  = cnt_q[0];
  assign cnt_accepted = cnt_q[1];
  assign cnt_busy     = cnt_q[2];

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_offered == '0 && cnt_accepted == '0 && cnt_busy == '0));
endmodule

// File: rtl/trig_frontend.sv
module trig_frontend #(
  parameter int DATA_W     = 16,
  parameter int WIN_LEN    = 4,
  parameter int MAX_DLY    = 32,
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = 32,
  localparam int DLY_AW    = $clog2(MAX_DLY),
  localparam int FIFO_AW   = $clog2(FIFO_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_clr,
  input  logic              cfg_load,
  input  logic [DATA_W-1:0] cfg_threshold,
  input  logic [DLY_AW-1:0] cfg_delay,
  input  logic [DATA_W-1:0] smp_in,
  output logic              busy,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [CNT_W-1:0]  cnt_offered,
  output logic [CNT_W-1:0]  cnt_accepted,
  output logic [CNT_W-1:0]  cnt_busy
);
  localparam int SEQ_W = 16;

  logic [DLY_AW-1:0]  tap_sel;
  logic [DATA_W-1:0]  dly_smp, wr_data;
  logic [FIFO_AW:0]   free_words;
  logic               cand, accept, wr_en;

  trig_delay_line #(.DATA_W(DATA_W), .MAX_DLY(MAX_DLY), .DLY_AW(DLY_AW)) dly_i (
    .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .tap_sel(tap_sel), .smp_out(dly_smp)
  );

  trig_capture #(.DATA_W(DATA_W), .WIN_LEN(WIN_LEN), .DLY_AW(DLY_AW),
                 .SEQ_W(SEQ_W), .FREE_W(FIFO_AW+1)) cap_i (
    .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .dly_smp(dly_smp),
    .cfg_load(cfg_load), .cfg_threshold(cfg_threshold), .cfg_delay(cfg_delay),
    .free_words(free_words), .tap_sel(tap_sel), .busy(busy), .cand(cand),
    .accept(accept), .wr_en(wr_en), .wr_data(wr_data)
  );

  trig_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH), .AW(FIFO_AW)) fifo_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_ready(out_ready), .rd_valid(out_valid), .rd_data(out_data),
    .free_words(free_words)
  );

  trig_counters #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc_offered(cand),
    .inc_accepted(accept), .inc_busy(busy), .cnt_offered(cnt_offered),
    .cnt_accepted(cnt_accepted), .cnt_busy(cnt_busy)
  );
endmodule

// File: tb/trig_frontend_tb_top.sv
`timescale 1ns/1ps
module trig_frontend_tb_top;
  localparam int DW = 16, WIN = 4, MAXD = 32, DEPTH = 16, CW = 32, DAW = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cnt_clr, cfg_load, out_ready, busy, out_valid;
  logic [DW-1:0] cfg_threshold, smp_in, out_data;
  logic [DAW-1:0] cfg_delay;
  logic [CW-1:0] cnt_offered, cnt_accepted, cnt_busy;

  trig_frontend dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr), .cfg_load(cfg_load),
    .cfg_threshold(cfg_threshold), .cfg_delay(cfg_delay), .smp_in(smp_in),
    .busy(busy), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .cnt_offered(cnt_offered), .cnt_accepted(cnt_accepted), .cnt_busy(cnt_busy)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // reference model state
  logic [DW-1:0]  m_thr;
  logic [DAW-1:0] m_dly;
  int             m_left;
  logic [15:0]    m_seq;
  logic [DW-1:0]  m_hist [MAXD];
  logic [DW-1:0]  m_q [$];
  logic [CW-1:0]  m_off, m_acc, m_bsy;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit model_busy();
    return (m_left != 0) || ((DEPTH - m_q.size()) < WIN + 1);
  endfunction

  task automatic cycle(input logic [DW-1:0] s, input bit rdy, input bit ld,
                       input logic [DW-1:0] th, input logic [DAW-1:0] dl, input bit clr);
    bit idle, mb, cand, acc;
    @(negedge clk);
    smp_in = s; out_ready = rdy; cfg_load = ld; cfg_threshold = th;
    cfg_delay = dl; cnt_clr = clr;
    idle = (m_left == 0);
    mb   = model_busy();
    chk("R4 R6 busy", 64'(busy), 64'(mb));
    chk("R7 out_valid", 64'(out_valid), 64'(m_q.size() != 0));
    if (m_q.size() != 0) chk("R3 R7 out_data", 64'(out_data), 64'(m_q[0]));
    chk("R2 R9 cnt_offered", 64'(cnt_offered), 64'(m_off));
    chk("R5 R8 cnt_accepted", 64'(cnt_accepted), 64'(m_acc));
    chk("R8 cnt_busy", 64'(cnt_busy), 64'(m_bsy));
    cand = (s > m_thr);
    acc  = cand && !mb;
    if (m_q.size() != 0 && rdy) void'(m_q.pop_front());
    if (acc) begin
      m_q.push_back(DW'(m_seq));
      m_seq++;
      m_left = WIN;
    end else if (m_left > 0) begin
      m_q.push_back(m_hist[m_dly]);
      m_left--;
    end
    if (clr) begin
      m_off = '0; m_acc = '0; m_bsy = '0;
    end else begin
      m_off += CW'(cand); m_acc += CW'(acc); m_bsy += CW'(mb);
    end
    if (ld && idle) begin
      m_thr = th; m_dly = dl;
    end
    for (int k = MAXD - 1; k > 0; k--) m_hist[k] = m_hist[k-1];
    m_hist[0] = s;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] thr_r;
    void'($urandom(32'd12345));
    rst_n = 1'b0; cnt_clr = 1'b0; cfg_load = 1'b0; cfg_threshold = '0;
    cfg_delay = '0; smp_in = '0; out_ready = 1'b0;
    m_thr = '0; m_dly = '0; m_left = 0; m_seq = '0;
    m_off = '0; m_acc = '0; m_bsy = '0;
    for (int k = 0; k < MAXD; k++) m_hist[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 out_valid", 64'(out_valid), 64'd0);
    chk("R1 cnt_offered", 64'(cnt_offered), 64'd0);
    chk("R1 cnt_accepted", 64'(cnt_accepted), 64'd0);
    chk("R1 cnt_busy", 64'(cnt_busy), 64'd0);

    // R9 load threshold 100, delay 1
    cycle(16'd0, 1'b1, 1'b1, 16'd100, 5'd0, 1'b0);
    // R2 equal sample is not a candidate, one above is
    cycle(16'd100, 1'b1, 1'b0, 16'd0, 5'd0, 1'b0);
    cycle(16'd101, 1'b1, 1'b0, 16'd0, 5'd0, 1'b0);
    // R5 candidates during the whole capture, including last cycle; R9 load ignored
    for (int i = 0; i < WIN; i++)
      cycle(16'd200 + 16'(i), 1'b1, (i == 1), 16'd5, 5'd3, 1'b0);
    // first idle cycle after capture: accepted
    cycle(16'd150, 1'b1, 1'b0, 16'd0, 5'd0, 1'b0);
    for (int i = 0; i < WIN + 2; i++) cycle(16'd50, 1'b1, 1'b0, 16'd0, 5'd0, 1'b0);

    // R3 longest delay with a ramp
    cycle(16'd0, 1'b1, 1'b1, 16'd60000, 5'd31, 1'b0);
    for (int i = 0; i < 40; i++) cycle(16'(i + 1), 1'b1, 1'b0, 16'd0, 5'd0, 1'b0);
    cycle(16'd60001, 1'b1, 1'b0, 16'd0, 5'd0, 1'b0);
    for (int i = 0; i < 8; i++) cycle(16'(100 + i), 1'b1, 1'b0, 16'd0, 5'd0, 1'b0);

    // R8 clear pulse
    cycle(16'd60002, 1'b1, 1'b0, 16'd0, 5'd0, 1'b1);
    for (int i = 0; i < 6; i++) cycle(16'd0, 1'b1, 1'b0, 16'd0, 5'd0, 1'b0);

    // R6 stalled consumer with a trigger every cycle
    cycle(16'd0, 1'b1, 1'b1, 16'd10, 5'd2, 1'b0);
    for (int i = 0; i < 30; i++) cycle(16'd500, 1'b0, 1'b0, 16'd0, 5'd0, 1'b0);
    for (int i = 0; i < 30; i++) cycle(16'd0, 1'b1, 1'b0, 16'd0, 5'd0, 1'b0);

    // random phase
    thr_r = 16'd128;
    for (int i = 0; i < 4000; i++) begin
      bit ld, rdy, clr;
      ld  = ($urandom_range(0, 40) == 0);
      if (ld) thr_r = 16'($urandom_range(80, 200));
      rdy = ((i / 300) % 2 == 0) ? ($urandom_range(0, 3) != 0) : ($urandom_range(0, 5) == 0);
      clr = ($urandom_range(0, 500) == 0);
      cycle(16'($urandom_range(0, 255)), rdy, ld, thr_r, 5'($urandom_range(0, 31)), clr);
    end
    for (int i = 0; i < 40; i++) cycle(16'd0, 1'b1, 1'b0, 16'd0, 5'd0, 1'b0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule